// File: doc/BRIEF.md
# Dual-Processor Mailbox With Interrupt Control

This block links an 8-bit control processor and a 16-bit signal processor. The 8-bit side sees sixteen byte addresses. The lower half holds outgoing mailbox bytes, which it may write and read back. The upper half holds incoming mailbox bytes, which it may only read. The 16-bit side sees the same storage as whole words. It reads the outgoing words, writes the incoming words, and also reaches one 16-bit interrupt control word.

The control word gathers three pending flags for the signal-processor interrupt sources, a mask bit for each source, a global enable, a 3-bit code that picks the priority order, write-one clear bits, and one interrupt line toward the control processor. At most one signal-processor interrupt is presented at a time: the pending, unmasked source that ranks highest, and only while the global enable is set. All register reads are combinational from state. Every write takes effect at the next rising clock edge.

Top module: `mbox_irq_top`

## Requirements
- R1: After reset, every mailbox byte and word reads 0, the control word reads 0000h, `sp_int` is 000 and `cp_irq` is 0.
- R2: A byte write from the 8-bit side to address 2k (k = 0..3) sets the high byte of outgoing word k. A write to 2k+1 sets its low byte. Both bytes read back at the same addresses.
- R3: On the 16-bit side, a read of word address k (0..3) returns outgoing word k as {byte 2k, byte 2k+1}.
- R4: A 16-bit write to word address k (0..3) loads incoming word k. The 8-bit side reads its high byte at 08h+2k and its low byte at 09h+2k.
- R5: Byte writes to addresses 08h..0Fh change nothing. A 16-bit write to an address above 4 changes nothing and such an address reads 0.
- R6: A high level on `irq_src[i]` at a clock edge sets pending flag i. The control word holds IRQ2 at bit 15, IRQ1 at bit 14 and IRQ0 at bit 13. Written values of bits 15..13 are ignored.
- R7: Writing 1 to control bit 4, 3 or 2 clears pending IRQ2, IRQ1 or IRQ0 at that edge. Writing 0 leaves the flag as it is. A source that is high in the same cycle wins over the clear. Bits 4..0 always read 0.
- R8: Control bits 12, 11 and 10 are the masks of INT2, INT1 and INT0. A 1 keeps that source from being presented. The masks read back as written.
- R9: Control bit 8 is the global enable. While it is 0, `sp_int` is 000 whatever is pending.
- R10: Control bits 7..5 select the priority order, highest first: 000 = 0,1,2; 001 = 0,2,1; 010 = 1,0,2; 011 = 1,2,0; 100 = 2,0,1; 101 = 2,1,0. The reserved codes 110 and 111 use 0,1,2. The field reads back as written.
- R11: `sp_int` is one-hot or zero. Bit i is set when source i is pending, unmasked and globally enabled, and no higher-ranked source also qualifies.
- R12: Control bit 9 is read/write and drives `cp_irq` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | 4 | 8-bit side byte address |
| hb_wr | input | 1 | 8-bit side write strobe |
| hb_wdata | input | 8 | 8-bit side write data |
| hb_rdata | output | 8 | 8-bit side read data at hb_addr |
| ws_addr | input | 3 | 16-bit side address: 0..3 mailbox words, 4 control word |
| ws_wr | input | 1 | 16-bit side write strobe |
| ws_wdata | input | 16 | 16-bit side write data |
| ws_rdata | output | 16 | 16-bit side read data at ws_addr |
| irq_src | input | 3 | Interrupt source events, bit i for INTi |
| sp_int | output | 3 | Presented signal-processor interrupt, one-hot or zero |
| cp_irq | output | 1 | Interrupt toward the 8-bit side |

## Verification
Four properties are checked on every cycle: `sp_int` is never more than one-hot, it stays silent without the global enable, a set source or a clear bit always reaches its pending flag, and writes from the wrong side leave the incoming words unchanged. Only the bench scenarios can show the byte-to-word lane order, the reads that return to 0 and the full priority table with its reserved codes. The bench runs directed cases and then a long seeded random mix of writes and source events, and compares each result with its own model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int NSRC = 3;

    typedef enum logic [2:0] {
        ORD_012 = 3'd0,
        ORD_021 = 3'd1,
        ORD_102 = 3'd2,
        ORD_120 = 3'd3,
        ORD_201 = 3'd4,
        ORD_210 = 3'd5,
        ORD_RSV6 = 3'd6,
        ORD_RSV7 = 3'd7
    } prio_code_e;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] mask;
        logic            xirq;
        logic            gen;
        prio_code_e      code;
    } ictl_t;

endpackage

// File: rtl/mbox_regs.sv
module mbox_regs #(
    parameter int NW = 4,
    parameter int BW = 8,
    localparam int WW = 2 * BW,
    localparam int WI = $clog2(NW),
    localparam int BA = WI + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BA-1:0] hb_addr,
    input  logic          hb_wr,
    input  logic [BW-1:0] hb_wdata,
    output logic [BW-1:0] hb_rdata,
    input  logic [WI-1:0] ws_idx,
    input  logic          ws_wr,
    input  logic [WW-1:0] ws_wdata,
    output logic [WW-1:0] ws_rword
);

    typedef struct packed {
        logic [NW-1:0][WW-1:0] outw;
        logic [NW-1:0][WW-1:0] inw;
    } mb_t;

    mb_t st_d, st_q;
    logic [WI-1:0] hb_widx;
    logic          hb_upper;
    logic [WW-1:0] hb_word;

    assign hb_widx  = hb_addr[BA-2:1];
    assign hb_upper = hb_addr[BA-1];

    always_comb begin
        st_d = st_q;
        if (hb_wr && !hb_upper) begin
            if (hb_addr[0]) begin
                st_d.outw[hb_widx][BW-1:0] = hb_wdata;
            end else begin
                st_d.outw[hb_widx][WW-1:BW] = hb_wdata;
            end
        end
        if (ws_wr) begin
            st_d.inw[ws_idx] = ws_wdata;
        end
        hb_word  = hb_upper ? st_q.inw[hb_widx] : st_q.outw[hb_widx];
        hb_rdata = hb_addr[0] ? hb_word[BW-1:0] : hb_word[WW-1:BW];
        ws_rword = st_q.outw[ws_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the 8-bit side cannot alter the incoming words
    a_r5_in_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_wr && hb_upper && !ws_wr) |=> $stable(st_q.inw));

    // R4: a 16-bit write lands in the addressed incoming word
    a_r4_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        ws_wr |=> (st_q.inw[$past(ws_idx)] == $past(ws_wdata)));

    // R2: the 16-bit side never alters the outgoing words
    a_r2_out_owned: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_wr |=> $stable(st_q.outw));

endmodule

// File: rtl/prio_sel.sv
module prio_sel
    import mbox_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  prio_code_e      code,
    output logic [NSRC-1:0] grant
);

    logic [NSRC-1:0][1:0] rank_src;

    always_comb begin
        case (code)
            ORD_021: rank_src = {2'd1, 2'd2, 2'd0};
            ORD_102: rank_src = {2'd2, 2'd0, 2'd1};
            ORD_120: rank_src = {2'd0, 2'd2, 2'd1};
            ORD_201: rank_src = {2'd1, 2'd0, 2'd2};
            ORD_210: rank_src = {2'd0, 2'd1, 2'd2};
            default: rank_src = {2'd2, 2'd1, 2'd0};
        endcase
    end

    logic [NSRC:0] taken;
    assign taken[0] = 1'b0;

    logic [NSRC-1:0][NSRC-1:0] rank_grant;

    for (genvar r = 0; r < NSRC; r++) begin : g_rank
        logic hit;
        assign hit           = req[rank_src[r]] && !taken[r];
        assign taken[r+1]    = taken[r] || hit;
        assign rank_grant[r] = hit ? (NSRC'(1) << rank_src[r]) : '0;
    end

    always_comb begin
        grant = '0;
        for (int r = 0; r < NSRC; r++) begin
            grant = grant | rank_grant[r];
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import mbox_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [CW-1:0]   ctl_wdata,
    input  logic [NSRC-1:0] src,
    output logic [CW-1:0]   ctl_rdata,
    output logic [NSRC-1:0] sp_int,
    output logic            cp_irq
);

    ictl_t           st_d, st_q;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] req;

    always_comb begin
        st_d = st_q;
        clr  = ctl_wr ? ctl_wdata[4:2] : '0;
        st_d.pend = (st_q.pend & ~clr) | src;
        if (ctl_wr) begin
            st_d.mask = ctl_wdata[12:10];
            st_d.xirq = ctl_wdata[9];
            st_d.gen  = ctl_wdata[8];
            st_d.code = prio_code_e'(ctl_wdata[7:5]);
        end
        ctl_rdata = {st_q.pend, st_q.mask, st_q.xirq, st_q.gen, st_q.code, 5'b0};
        req       = st_q.gen ? (st_q.pend & ~st_q.mask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    prio_sel u_prio (
        .req  (req),
        .code (st_q.code),
        .grant(sp_int)
    );

    assign cp_irq = st_q.xirq;

    // R11: at most one interrupt presented
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sp_int));

    // R9: nothing presented without the global enable
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_int != '0) |-> st_q.gen);

    // R8: a masked source is never presented
    a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_int & st_q.mask) == '0);

    // R10: reserved codes rank INT0 first
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gen && st_q.code[2:1] == 2'b11 && st_q.pend[0] && !st_q.mask[0])
            |-> sp_int[0]);

    for (genvar i = 0; i < NSRC; i++) begin : g_src_chk
        // R6: a source event always sets its flag
        a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
            src[i] |=> st_q.pend[i]);
        // R7: a clear bit drops the flag unless the source is high
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && ctl_wdata[2+i] && !src[i]) |=> !st_q.pend[i]);
    end

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top #(
    parameter int NW = 4,
    parameter int BW = 8,
    localparam int WW = 2 * BW,
    localparam int WI = $clog2(NW),
    localparam int BA = WI + 2,
    localparam int WA = WI + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BA-1:0] hb_addr,
    input  logic          hb_wr,
    input  logic [BW-1:0] hb_wdata,
    output logic [BW-1:0] hb_rdata,
    input  logic [WA-1:0] ws_addr,
    input  logic          ws_wr,
    input  logic [WW-1:0] ws_wdata,
    output logic [WW-1:0] ws_rdata,
    input  logic [2:0]    irq_src,
    output logic [2:0]    sp_int,
    output logic          cp_irq
);

    localparam logic [WA-1:0] CTL_ADDR = WA'(NW);

    logic          is_mbox;
    logic          is_ctl;
    logic [WW-1:0] mb_rword;
    logic [WW-1:0] ctl_rword;

    assign is_mbox = !ws_addr[WA-1];
    assign is_ctl  = (ws_addr == CTL_ADDR);

    mbox_regs #(.NW(NW), .BW(BW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hb_addr (hb_addr),
        .hb_wr   (hb_wr),
        .hb_wdata(hb_wdata),
        .hb_rdata(hb_rdata),
        .ws_idx  (ws_addr[WI-1:0]),
        .ws_wr   (ws_wr && is_mbox),
        .ws_wdata(ws_wdata),
        .ws_rword(mb_rword)
    );

    irq_ctrl #(.CW(WW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ws_wr && is_ctl),
        .ctl_wdata(ws_wdata),
        .src      (irq_src),
        .ctl_rdata(ctl_rword),
        .sp_int   (sp_int),
        .cp_irq   (cp_irq)
    );

    always_comb begin
        if (is_mbox) begin
            ws_rdata = mb_rword;
        end else if (is_ctl) begin
            ws_rdata = ctl_rword;
        end else begin
            ws_rdata = '0;
        end
    end

    // R12: the cross interrupt follows control bit 9
    a_r12_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_wr && is_ctl) |=> (cp_irq == $past(ws_wdata[9])));

endmodule

// File: tb/mbox_irq_top_tb.sv
module mbox_irq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hb_addr = '0;
    logic        hb_wr = 1'b0;
    logic [7:0]  hb_wdata = '0;
    logic [7:0]  hb_rdata;
    logic [2:0]  ws_addr = '0;
    logic        ws_wr = 1'b0;
    logic [15:0] ws_wdata = '0;
    logic [15:0] ws_rdata;
    logic [2:0]  irq_src = '0;
    logic [2:0]  sp_int;
    logic        cp_irq;

    always #4 clk = ~clk;

    mbox_irq_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .hb_addr(hb_addr), .hb_wr(hb_wr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .ws_addr(ws_addr), .ws_wr(ws_wr), .ws_wdata(ws_wdata), .ws_rdata(ws_rdata),
        .irq_src(irq_src), .sp_int(sp_int), .cp_irq(cp_irq)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_out [8];
    logic [7:0] m_in  [8];
    logic [2:0] m_pend, m_mask, m_code;
    logic       m_x, m_g;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_int(input logic [2:0] p, input logic [2:0] m,
                                           input logic g, input logic [2:0] c);
        int ord [3];
        logic [2:0] q;
        case (c)
            3'd1: ord = '{0, 2, 1};
            3'd2: ord = '{1, 0, 2};
            3'd3: ord = '{1, 2, 0};
            3'd4: ord = '{2, 0, 1};
            3'd5: ord = '{2, 1, 0};
            default: ord = '{0, 1, 2};
        endcase
        q = g ? (p & ~m) : 3'b000;
        for (int r = 0; r < 3; r++) begin
            if (q[ord[r]]) return 3'(1 << ord[r]);
        end
        return 3'b000;
    endfunction

    function automatic logic [15:0] exp_ctl();
        return {m_pend, m_mask, m_x, m_g, m_code, 5'b0};
    endfunction

    task automatic byte_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
        @(negedge clk);
        hb_wr = 1'b0;
        if (a < 4'd8) m_out[a] = d;
    endtask

    task automatic word_wr(input logic [2:0] a, input logic [15:0] d, input logic [2:0] s);
        @(negedge clk);
        ws_addr = a; ws_wdata = d; ws_wr = 1'b1; irq_src = s;
        @(negedge clk);
        ws_wr = 1'b0; irq_src = 3'b000;
        if (a < 3'd4) begin
            m_in[2*a] = d[15:8];
            m_in[2*a+1] = d[7:0];
        end else if (a == 3'd4) begin
            m_pend = (m_pend & ~d[4:2]) | s;
            m_mask = d[12:10]; m_x = d[9]; m_g = d[8]; m_code = d[7:5];
            s = 3'b000;
        end
        m_pend = m_pend | s;
    endtask

    task automatic pulse(input logic [2:0] s);
        @(negedge clk);
        irq_src = s;
        @(negedge clk);
        irq_src = 3'b000;
        m_pend = m_pend | s;
    endtask

    task automatic rd_byte(input string tag, input logic [3:0] a);
        hb_addr = a; #1;
        chk(tag, {8'h00, hb_rdata}, {8'h00, (a < 4'd8) ? m_out[a] : m_in[a-8]});
    endtask

    task automatic rd_word(input string tag, input logic [2:0] a);
        logic [15:0] e;
        ws_addr = a; #1;
        if (a < 3'd4) e = {m_out[2*a], m_out[2*a+1]};
        else if (a == 3'd4) e = exp_ctl();
        else e = 16'h0000;
        chk(tag, ws_rdata, e);
    endtask

    task automatic chk_int(input string tag);
        chk(tag, {13'd0, sp_int}, {13'd0, exp_int(m_pend, m_mask, m_g, m_code)});
        chk({tag, " cp_irq"}, {15'd0, cp_irq}, {15'd0, m_x});
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int i = 0; i < 8; i++) begin m_out[i] = '0; m_in[i] = '0; end
        m_pend = '0; m_mask = '0; m_code = '0; m_x = 1'b0; m_g = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) rd_byte("R1 reset byte", 4'(a));
        for (int a = 0; a < 8; a++) rd_word("R1 reset word", 3'(a));
        chk_int("R1 reset int");

        // R2 / R3 byte lanes
        byte_wr(4'h0, 8'hA1); byte_wr(4'h1, 8'hB2);
        byte_wr(4'h6, 8'hC3); byte_wr(4'h7, 8'hD4);
        rd_byte("R2 byte 0", 4'h0); rd_byte("R2 byte 7", 4'h7);
        ws_addr = 3'd0; #1; chk("R3 word0 order", ws_rdata, 16'hA1B2);
        ws_addr = 3'd3; #1; chk("R3 word3 order", ws_rdata, 16'hC3D4);

        // R4 incoming words
        word_wr(3'd1, 16'h5A3C, 3'b000);
        hb_addr = 4'hA; #1; chk("R4 high byte at 0Ah", {8'h0, hb_rdata}, 16'h005A);
        hb_addr = 4'hB; #1; chk("R4 low byte at 0Bh", {8'h0, hb_rdata}, 16'h003C);

        // R5 ignored writes
        byte_wr(4'hA, 8'hFF);
        hb_addr = 4'hA; #1; chk("R5 upper byte write ignored", {8'h0, hb_rdata}, 16'h005A);
        word_wr(3'd6, 16'hFFFF, 3'b000);
        rd_word("R5 unused addr reads 0", 3'd6);
        for (int a = 0; a < 5; a++) rd_word("R5 nothing disturbed", 3'(a));

        // R6 pending set, written pending bits ignored
        word_wr(3'd4, 16'hE000, 3'b000);
        rd_word("R6 pend not writable", 3'd4);
        pulse(3'b010);
        ws_addr = 3'd4; #1; chk("R6 IRQ1 at bit14", ws_rdata, 16'h4000);
        chk_int("R9 disabled no int");

        // R9 / R11 enable
        word_wr(3'd4, 16'h0100, 3'b000);
        chk_int("R9 enabled int");
        chk("R11 INT1 presented", {13'd0, sp_int}, 16'h0002);

        // R10 full table with all three pending
        pulse(3'b101);
        for (int c = 0; c < 8; c++) begin
            word_wr(3'd4, 16'h0100 | 16'(c << 5), 3'b000);
            chk_int($sformatf("R10 order code %0d", c));
            rd_word("R10 code readback", 3'd4);
        end

        // R8 masks
        word_wr(3'd4, 16'h0500, 3'b000);
        chk("R8 mask INT0 gives INT1", {13'd0, sp_int}, 16'h0002);
        word_wr(3'd4, 16'h1D00, 3'b000);
        chk("R8 all masked", {13'd0, sp_int}, 16'h0000);
        rd_word("R8 mask readback", 3'd4);

        // R7 clears, set wins, low bits read 0
        word_wr(3'd4, 16'h0108, 3'b000);
        rd_word("R7 clear IRQ1", 3'd4);
        word_wr(3'd4, 16'h0113, 3'b100);
        rd_word("R7 set wins over clear", 3'd4);
        chk("R7 IRQ2 still pending", {15'd0, ws_rdata[15]}, 16'h0001);
        chk("R7 low bits zero", {11'd0, ws_rdata[4:0]}, 16'h0000);

        // R12 cross interrupt
        word_wr(3'd4, 16'h0200, 3'b000);
        chk("R12 cp_irq set", {15'd0, cp_irq}, 16'h0001);
        word_wr(3'd4, 16'h0000, 3'b000);
        chk("R12 cp_irq clear", {15'd0, cp_irq}, 16'h0000);

        // random mix
        for (int n = 0; n < 2000; n++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: byte_wr(4'($urandom_range(0, 15)), 8'($urandom));
                1: word_wr(3'($urandom_range(0, 7)), 16'($urandom), 3'b000);
                2: word_wr(3'd4, 16'($urandom) | 16'h0100, 3'($urandom));
                default: pulse(3'($urandom));
            endcase
            chk_int("R11 random int");
            rd_byte("R2 R4 random byte", 4'($urandom_range(0, 15)));
            rd_word("R3 random word", 3'($urandom_range(0, 7)));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule